// File: doc/BRIEF.md
# UART Sample-Tick Generator with Fractional Prescaler

This block produces the timing enables that a 16550-style UART core uses to sample its receive line and to shift its transmit data. The incoming UART clock first passes through an optional fractional prescaler. The prescaler is programmed in eighths, so a setting of 0x08 divides by one and 0x20 divides by four. A standard 16-bit baud divisor follows the prescaler. A programmable oversampling counter then groups a chosen number of sample enables, from 4 to 16, into one bit period.

Configuration reaches the block as decoded write strobes with a shared data byte, plus a separate 16-bit divisor word. Four byte-wide registers can be read back through an address-selected read port: prescaler, oversampling, modem control and feature control. Bit 7 of the modem-control register switches the prescaler in or out. Its reset value is the inverse of a clock-select pin, so a board can pick standard or fast-clock operation without firmware.

The two outputs are single-cycle, active-high enables, and they are combinational from registered state. A write to the divisor, prescaler or oversampling register restarts every counter. The UART core therefore sees a clean phase for the new rate.

Top module: `uart_tick_gen`

## Requirements
- R1: With reset held for at least one clock, the readback is prescaler 0x08, oversampling 0x00 and feature control 0x00. Modem control reads as 0x80 when clksel_pin is 0 and 0x00 when it is 1. The divisor is 1.
- R2: With modem-control bit 7 set and an effective prescaler setting P, call the cycle after a restart n = 0. The prescaled tick in cycle n fires exactly when floor((n+1)·8/P) > floor(n·8/P). This gives an average of 8/P ticks per clock.
- R3: A prescaler value below 0x08 behaves as 0x08. The register still reads back the value that was written.
- R4: With modem-control bit 7 clear, the prescaler is bypassed and a tick fires in every clock, whatever the prescaler value.
- R5: sample_en fires on every D-th prescaled tick counted from the restart. D is the divisor, and a divisor of 0 acts as 1.
- R6: bit_en fires on every N-th sample_en counted from the restart. N is taken from oversampling bits 3:0: codes 4 to 15 give N equal to the code, and codes 0 to 3 give N = 16.
- R7: A write to the divisor, prescaler or oversampling register clears all counters. The following cycle is cycle n = 0 of the new timing.
- R8: Modem-control bits 7:6 take a write only while feature-control bit 4 is 1, and otherwise keep their value. Bits 5:0 always take the written value.
- R9: rd_data returns prescaler at rd_addr 0, oversampling at 1, modem control at 2 and feature control at 3.
- R10: bit_en is never high in a cycle in which sample_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | UART input clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clksel_pin | input | 1 | Clock-select strap; its inverse loads modem-control bit 7 at reset |
| wr_div | input | 1 | Write strobe for the baud divisor |
| div_wdata | input | 16 | Divisor value written by wr_div |
| wr_psc | input | 1 | Write strobe for the prescaler register |
| wr_ovs | input | 1 | Write strobe for the oversampling register |
| wr_mcr | input | 1 | Write strobe for the modem-control register |
| wr_efr | input | 1 | Write strobe for the feature-control register |
| wr_data | input | 8 | Byte written by the byte-wide strobes |
| rd_addr | input | 2 | Read register select |
| rd_data | output | 8 | Selected register contents |
| sample_en | output | 1 | One-cycle sample-clock enable |
| bit_en | output | 1 | One-cycle bit-period enable |

## Verification
The embedded properties assume that write strobes are low while reset is asserted. They also assume that a change to the divisor, prescaler or oversampling value arrives only through its own strobe, which restarts the counters in the same edge. Under those assumptions the accumulator and counter range checks hold. The bench drives each strobe for exactly one cycle on the falling edge and keeps strobes low during reset. Every randomized configuration ends with an oversampling write, so that observation starts from a known restart.

// File: rtl/uart_tick_pkg.sv
package uart_tick_pkg;

   localparam int unsigned REG_W        = 8;
   localparam int unsigned OVS_CODE_W   = 4;
   localparam int unsigned OVS_CNT_W    = 5;
   localparam int unsigned OVS_MIN      = 4;
   localparam int unsigned OVS_DEFAULT  = 16;
   localparam int unsigned PSC_ON_BIT   = 7;
   localparam int unsigned SIR_BIT      = 6;
   localparam int unsigned UNLOCK_BIT   = 4;

   typedef enum logic [1:0] {
      RA_PSC = 2'd0,
      RA_OVS = 2'd1,
      RA_MCR = 2'd2,
      RA_EFR = 2'd3
   } rd_sel_e;

   function automatic logic [OVS_CNT_W-1:0] ovs_count(input logic [OVS_CODE_W-1:0] code);
      if (code < OVS_CODE_W'(OVS_MIN))
         return OVS_CNT_W'(OVS_DEFAULT);
      else
         return OVS_CNT_W'(code);
   endfunction

endpackage

// File: rtl/tick_cfg_regs.sv
module tick_cfg_regs
   import uart_tick_pkg::*;
#(
   parameter int unsigned DIV_W    = 16,
   parameter int unsigned FRAC_W   = 3
)(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  clksel_pin,
   input  logic                  wr_div,
   input  logic [DIV_W-1:0]      div_wdata,
   input  logic                  wr_psc,
   input  logic                  wr_ovs,
   input  logic                  wr_mcr,
   input  logic                  wr_efr,
   input  logic [REG_W-1:0]      wr_data,
   input  logic [1:0]            rd_addr,
   output logic [REG_W-1:0]      rd_data,
   output logic [REG_W-1:0]      psc_eff,
   output logic                  psc_on,
   output logic [DIV_W-1:0]      div_eff,
   output logic [OVS_CNT_W-1:0]  ovs_eff,
   output logic                  restart
);

   localparam logic [REG_W-1:0] PSC_UNITY = REG_W'(1 << FRAC_W);
   localparam logic [DIV_W-1:0] DIV_ONE   = DIV_W'(1);

   logic [REG_W-1:0] psc_q, ovs_q, mcr_q, efr_q;
   logic [DIV_W-1:0] div_q;
   logic             unlocked;

   assign unlocked = efr_q[UNLOCK_BIT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         psc_q <= PSC_UNITY;
         ovs_q <= '0;
         efr_q <= '0;
         div_q <= DIV_ONE;
         mcr_q <= '0;
         mcr_q[PSC_ON_BIT] <= ~clksel_pin;
      end else begin
         if (wr_psc) psc_q <= wr_data;
         if (wr_ovs) ovs_q <= wr_data;
         if (wr_efr) efr_q <= wr_data;
         if (wr_div) div_q <= div_wdata;
         if (wr_mcr) begin
            mcr_q[SIR_BIT-1:0] <= wr_data[SIR_BIT-1:0];
            if (unlocked)
               mcr_q[PSC_ON_BIT:SIR_BIT] <= wr_data[PSC_ON_BIT:SIR_BIT];
         end
      end
   end

   assign psc_eff = (psc_q < PSC_UNITY) ? PSC_UNITY : psc_q;
   assign psc_on  = mcr_q[PSC_ON_BIT];
   assign div_eff = (div_q == '0) ? DIV_ONE : div_q;
   assign ovs_eff = ovs_count(ovs_q[OVS_CODE_W-1:0]);
   assign restart = wr_div | wr_psc | wr_ovs;

   always_comb begin
      unique case (rd_sel_e'(rd_addr))
         RA_PSC:  rd_data = psc_q;
         RA_OVS:  rd_data = ovs_q;
         RA_MCR:  rd_data = mcr_q;
         RA_EFR:  rd_data = efr_q;
         default: rd_data = '0;
      endcase
   end

   AST_MCR_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_mcr && !unlocked) |=> $stable(mcr_q[PSC_ON_BIT:SIR_BIT])) else $error("mcr lock"); // R8

endmodule

// File: rtl/tick_frac_psc.sv
module tick_frac_psc
   import uart_tick_pkg::*;
#(
   parameter int unsigned FRAC_W  = 3,
   parameter bit          HAS_PSC = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic              psc_on,
   input  logic [REG_W-1:0]  psc_eff,
   output logic              tick
);

   localparam int unsigned SUM_W = REG_W + 1;
   localparam logic [SUM_W-1:0] STEP = SUM_W'(1 << FRAC_W);

   if (FRAC_W >= REG_W) begin : g_bad_frac
      $error("FRAC_W must be smaller than REG_W");
   end

   if (HAS_PSC) begin : g_accum
      logic [REG_W-1:0] acc_q;
      logic [SUM_W-1:0] sum;
      logic [SUM_W-1:0] lim;
      logic             hit;

      assign sum  = {1'b0, acc_q} + STEP;
      assign lim  = {1'b0, psc_eff};
      assign hit  = (sum >= lim);
      assign tick = !psc_on || hit;

      always_ff @(posedge clk) begin
         if (!rst_n || restart || !psc_on)
            acc_q <= '0;
         else if (hit)
            acc_q <= REG_W'(sum - lim);
         else
            acc_q <= REG_W'(sum);
      end

      AST_ACC_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
         acc_q < psc_eff) else $error("accumulator overrun"); // R2
      AST_RESTART_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
         $past(restart) |-> (acc_q == '0)) else $error("restart phase"); // R7
   end else begin : g_bypass
      logic unused_cfg;
      assign unused_cfg = ^{clk, rst_n, restart, psc_on, psc_eff};
      assign tick = 1'b1 | unused_cfg;
   end

endmodule

// File: rtl/tick_mod_counter.sv
module tick_mod_counter #(
   parameter int unsigned CNT_W = 16
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic              step,
   input  logic [CNT_W-1:0]  modulus,
   output logic              wrap
);

   logic [CNT_W-1:0] cnt_q;
   logic             at_end;

   if (CNT_W < 1) begin : g_bad_w
      $error("CNT_W must be at least 1");
   end

   assign at_end = (cnt_q == modulus - CNT_W'(1));
   assign wrap   = step && at_end;

   always_ff @(posedge clk) begin
      if (!rst_n || restart)
         cnt_q <= '0;
      else if (step)
         cnt_q <= at_end ? '0 : cnt_q + CNT_W'(1);
   end

   AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      !restart |=> (cnt_q < modulus)) else $error("counter out of range"); // R5

endmodule

// File: rtl/uart_tick_gen.sv
module uart_tick_gen
   import uart_tick_pkg::*;
#(
   parameter int unsigned DIV_W   = 16,
   parameter int unsigned FRAC_W  = 3,
   parameter bit          HAS_PSC = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clksel_pin,
   input  logic              wr_div,
   input  logic [DIV_W-1:0]  div_wdata,
   input  logic              wr_psc,
   input  logic              wr_ovs,
   input  logic              wr_mcr,
   input  logic              wr_efr,
   input  logic [7:0]        wr_data,
   input  logic [1:0]        rd_addr,
   output logic [7:0]        rd_data,
   output logic              sample_en,
   output logic              bit_en
);

   if (DIV_W < 1 || DIV_W > 16) begin : g_bad_div
      $error("DIV_W must lie in 1..16");
   end

   logic [REG_W-1:0]     psc_eff;
   logic                 psc_on;
   logic [DIV_W-1:0]     div_eff;
   logic [OVS_CNT_W-1:0] ovs_eff;
   logic                 restart;
   logic                 tick;

   tick_cfg_regs #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .clksel_pin (clksel_pin),
      .wr_div     (wr_div),
      .div_wdata  (div_wdata),
      .wr_psc     (wr_psc),
      .wr_ovs     (wr_ovs),
      .wr_mcr     (wr_mcr),
      .wr_efr     (wr_efr),
      .wr_data    (wr_data),
      .rd_addr    (rd_addr),
      .rd_data    (rd_data),
      .psc_eff    (psc_eff),
      .psc_on     (psc_on),
      .div_eff    (div_eff),
      .ovs_eff    (ovs_eff),
      .restart    (restart)
   );

   tick_frac_psc #(.FRAC_W(FRAC_W), .HAS_PSC(HAS_PSC)) u_psc (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .psc_on  (psc_on),
      .psc_eff (psc_eff),
      .tick    (tick)
   );

   tick_mod_counter #(.CNT_W(DIV_W)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .step    (tick),
      .modulus (div_eff),
      .wrap    (sample_en)
   );

   tick_mod_counter #(.CNT_W(OVS_CNT_W)) u_ovs (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .step    (sample_en),
      .modulus (ovs_eff),
      .wrap    (bit_en)
   );

   AST_BIT_IN_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
      bit_en |-> sample_en) else $error("bit without sample"); // R10

endmodule

// File: tb/sim_uart_tick_gen.sv
module sim_uart_tick_gen;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        clksel_pin = 1'b0;
   logic        wr_div = 1'b0, wr_psc = 1'b0, wr_ovs = 1'b0, wr_mcr = 1'b0, wr_efr = 1'b0;
   logic [15:0] div_wdata = '0;
   logic [7:0]  wr_data = '0;
   logic [1:0]  rd_addr = '0;
   logic [7:0]  rd_data;
   logic        sample_en, bit_en;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #5 clk = ~clk;

   uart_tick_gen u0 (
      .clk(clk), .rst_n(rst_n), .clksel_pin(clksel_pin),
      .wr_div(wr_div), .div_wdata(div_wdata), .wr_psc(wr_psc), .wr_ovs(wr_ovs),
      .wr_mcr(wr_mcr), .wr_efr(wr_efr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .sample_en(sample_en), .bit_en(bit_en)
   );

   function automatic int eff_p(int psc, bit on);
      if (!on) return 8;
      return (psc < 8) ? 8 : psc;
   endfunction

   function automatic int eff_n(int code);
      return (code < 4) ? 16 : code;
   endfunction

   function automatic int eff_d(int dv);
      return (dv == 0) ? 1 : dv;
   endfunction

   task automatic check(string req, int act, int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic do_reset(bit pin);
      clksel_pin = pin;
      @(negedge clk) rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // which: 0 divisor, 1 prescaler, 2 oversampling, 3 modem control, 4 feature control
   task automatic wr(int which, int val);
      @(negedge clk);
      wr_data   = val[7:0];
      div_wdata = val[15:0];
      case (which)
         0: wr_div = 1'b1;
         1: wr_psc = 1'b1;
         2: wr_ovs = 1'b1;
         3: wr_mcr = 1'b1;
         default: wr_efr = 1'b1;
      endcase
      @(negedge clk);
      {wr_div, wr_psc, wr_ovs, wr_mcr, wr_efr} = '0;
   endtask

   task automatic rd(string req, int addr, int exp);
      rd_addr = addr[1:0];
      #1;
      check(req, int'(rd_data), exp);
   endtask

   // Called right after a restarting write returns, at the negedge of cycle n = 0.
   task automatic run_cmp(string req, int cycles, int p, int d, int nv);
      int bad_s = 0, bad_b = 0, first = -1, a_s = 0, e_s = 0, a_b = 0, e_b = 0;
      for (int n = 0; n < cycles; n++) begin
         int  k   = ((n + 1) * 8) / p;
         bit  tk  = (k > ((n * 8) / p));
         bit  es  = tk && ((k % d) == 0);
         bit  eb  = es && (((k / d) % nv) == 0);
         if (sample_en !== es) bad_s++;
         if (bit_en !== eb) bad_b++;
         if (first < 0 && (sample_en !== es || bit_en !== eb)) begin
            first = n; a_s = sample_en; e_s = es; a_b = bit_en; e_b = eb;
         end
         @(negedge clk);
      end
      n_tests++;
      if (bad_s + bad_b != 0) begin
         n_fail++;
         $display("FAIL %s cycle=%0d actual sample/bit=%0d/%0d expected=%0d/%0d (p=0x%0h d=%0d n=%0d)",
                  req, first, a_s, a_b, e_s, e_b, p, d, nv);
      end
   endtask

   task automatic setup(bit on, int psc, int dv, int code);
      wr(4, 8'h10);
      wr(3, on ? 8'h80 : 8'h00);
      wr(0, dv);
      wr(1, psc);
      wr(2, code);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin : stim
      void'($urandom(32'h5EED_0C95));

      // R1 reset values, strap low
      do_reset(1'b0);
      rd("R1 psc", 0, 8'h08);
      rd("R1 ovs", 1, 8'h00);
      rd("R1 mcr strap0", 2, 8'h80);
      rd("R1 efr", 3, 8'h00);
      // R1 divisor 1, prescaler unity, N=16 after reset
      run_cmp("R1 reset timing", 40, 8, 1, 16);

      // R1 strap high, R4 bypass then default timing
      do_reset(1'b1);
      rd("R1 mcr strap1", 2, 8'h00);
      wr(1, 8'h20);
      run_cmp("R4 bypass psc=0x20", 40, 8, 1, 16);

      // R8 lock: feature bit 4 clear
      wr(3, 8'hFF);
      rd("R8 locked write", 2, 8'h3F);
      wr(4, 8'h10);
      wr(3, 8'h43);
      rd("R8 unlocked write", 2, 8'h43);
      rd("R9 efr read", 3, 8'h10);

      // R2 divide by 4 and by 1.5
      setup(1'b1, 8'h20, 1, 4);
      rd("R9 psc read", 0, 8'h20);
      rd("R9 ovs read", 1, 8'h04);
      run_cmp("R2 psc=0x20", 64, 32, 1, 4);
      setup(1'b1, 8'h0C, 1, 5);
      run_cmp("R2 psc=0x0C", 60, 12, 1, 5);

      // R3 below-range prescaler
      setup(1'b1, 8'h03, 1, 4);
      rd("R3 readback", 0, 8'h03);
      run_cmp("R3 psc=0x03 acts 0x08", 40, 8, 1, 4);

      // R5 divisor 0 acts as 1, divisor 3
      setup(1'b1, 8'h10, 0, 4);
      run_cmp("R5 div=0", 60, 16, 1, 4);
      setup(1'b1, 8'h08, 3, 6);
      run_cmp("R5 div=3", 80, 8, 3, 6);

      // R6 codes 2 and 15
      setup(1'b1, 8'h08, 1, 2);
      run_cmp("R6 code=2 acts 16", 70, 8, 1, 16);
      setup(1'b1, 8'h08, 1, 15);
      run_cmp("R6 code=15", 70, 8, 1, 15);

      // R7 restart mid-stream: run part-way, then rewrite divisor
      setup(1'b1, 8'h0B, 2, 4);
      repeat (7) @(negedge clk);
      wr(0, 2);
      run_cmp("R7 restart on divisor write", 80, 11, 2, 4);

      // Randomized configurations, R2 R4 R5 R6 R10
      for (int t = 0; t < 30; t++) begin
         int  psc  = 1 + ($urandom % 48);
         int  dv   = $urandom % 5;
         int  code = $urandom % 16;
         bit  on   = ($urandom % 4) != 0;
         setup(on, psc, dv, code);
         run_cmp("R2 R4 R5 R6 R10 random", 400, eff_p(psc, on), eff_d(dv), eff_n(code));
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule